// File: doc/BRIEF.md
# Intel HEX stream loader

This block sits after a serial receiver and turns a stream of ASCII characters in Intel HEX form into writes on a plain memory port. Each record opens with a colon (3AH) and is followed by hex character pairs. The pairs give a length, a 16-bit offset, a record type, the payload and a checksum. Payload bytes of data records go out on the write port as soon as each byte is complete. The address is the current segment base plus the record offset plus the byte index.

Three record types are understood: data (00H), end of file (01H) and extended segment address (02H). A valid end-of-file record marks the load complete. Any fault ends the load for good, with a fixed code held on `err_code` until reset. The faults are a receiver framing strobe, a stray character, an unknown type, a wrong length or a bad checksum. The loader does not resynchronise on the next record.

Top module: `hex_loader`

## Requirements
- R1: After reset `wr_en`, `busy` and `done` are 0, `err_code` is 00H and the segment base is 0.
- R2: Between records only the byte 3AH is legal. It opens a record and `busy` goes high on the next cycle. Any other byte there sets error E1H. `busy` stays high until the checksum has been taken.
- R3: Inside a record the characters 0-9, A-F and a-f are hex digits, and each byte is sent high digit first. Any other character inside a record sets error E1H.
- R4: Each payload byte of a type 00H record is written once. `wr_en` is high for the single cycle after the byte's second character is accepted. The address is (base + ((offset + index) mod 65536)) taken to `ADDR_W` bits, where index counts from 0.
- R5: A type 02H record of length 2 with a good checksum sets the base to its big-endian value times 16. The new base applies from the following record on.
- R6: A type 01H record of length 0 with a good checksum sets `done` and clears `busy`. After that all input is ignored: there are no writes and `err_code` stays 00H.
- R7: A record type other than 00H, 01H or 02H sets error E2H as soon as the type byte is complete.
- R8: A type 01H record whose length is not 0, or a type 02H record whose length is not 2, sets error E4H.
- R9: The 8-bit sum of the length, both offset bytes, the type, the payload and the checksum byte must be 00H. Otherwise error E3H is set.
- R10: A framing strobe sets error A1H at any point before `done` or an error. It wins over a byte arriving in the same cycle.
- R11: Once a code is set it holds until reset. `busy` is then low, no write occurs and further input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_byte | input | 8 | Received character |
| rx_frame_err | input | 1 | Receiver framing-error strobe |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Memory write address |
| wr_data | output | 8 | Memory write data |
| busy | output | 1 | A record is being parsed |
| done | output | 1 | A valid end-of-file record was seen |
| err_code | output | 8 | 00H, or the latched fault code |

## Verification
The assertions assume that reset is asserted from time zero. They also assume that the receiver presents at most one character per cycle and that the framing strobe is a plain level sampled on each edge. The stimulus holds `rx_valid` for one cycle per character with an idle cycle between characters. It raises the framing strobe only on chosen cycles, sometimes together with a character to test priority. The checks also take for granted that segment and sticky-state changes follow only from accepted characters. The stimulus therefore applies a fresh reset before each sweep point that needs a clean loader.

// File: rtl/hexld_pkg.sv
package hexld_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LEN,
        ST_AHI,
        ST_ALO,
        ST_TYPE,
        ST_DATA,
        ST_CSUM,
        ST_DONE,
        ST_FAULT
    } ld_state_t;

    localparam logic [7:0] START_MARK = 8'h3A;

    localparam logic [7:0] REC_DATA = 8'h00;
    localparam logic [7:0] REC_EOF  = 8'h01;
    localparam logic [7:0] REC_SEG  = 8'h02;

    localparam logic [7:0] CODE_NONE   = 8'h00;
    localparam logic [7:0] CODE_FRAME  = 8'hA1;
    localparam logic [7:0] CODE_FORMAT = 8'hE1;
    localparam logic [7:0] CODE_TYPE   = 8'hE2;
    localparam logic [7:0] CODE_SUM    = 8'hE3;
    localparam logic [7:0] CODE_LEN    = 8'hE4;

    typedef struct packed {
        ld_state_t   st;
        logic [7:0]  len;
        logic [15:0] off;
        logic [7:0]  rtype;
        logic [7:0]  idx;
        logic [7:0]  sum;
        logic [15:0] seg;
        logic [15:0] seg_new;
        logic [7:0]  err;
    } ld_regs_t;

endpackage

// File: rtl/hexld_ascii.sv
module hexld_ascii (
    input  logic [7:0] ch,
    output logic       is_hex,
    output logic [3:0] nib
);
    always_comb begin
        is_hex = 1'b0;
        nib    = 4'h0;
        if (ch >= 8'h30 && ch <= 8'h39) begin
            is_hex = 1'b1;
            nib    = ch[3:0];
        end else if ((ch >= 8'h41 && ch <= 8'h46) || (ch >= 8'h61 && ch <= 8'h66)) begin
            is_hex = 1'b1;
            nib    = ch[3:0] + 4'd9;
        end
    end
endmodule

// File: rtl/hexld_pair.sv
module hexld_pair (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       take,
    input  logic [3:0] nib,
    output logic       byte_vld,
    output logic [7:0] byte_val
);
    typedef struct packed {
        logic       half;
        logic [3:0] hi;
    } pair_t;

    pair_t pr_d, pr_q;

    always_comb begin
        pr_d = pr_q;
        if (clr) begin
            pr_d.half = 1'b0;
        end else if (take) begin
            pr_d.half = ~pr_q.half;
            if (!pr_q.half) pr_d.hi = nib;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pr_q <= '0;
        else        pr_q <= pr_d;
    end

    assign byte_vld = take & pr_q.half & ~clr;
    assign byte_val = {pr_q.hi, nib};
endmodule

// File: rtl/hex_loader.sv
module hex_loader
    import hexld_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_frame_err,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              busy,
    output logic              done,
    output logic [7:0]        err_code
);
    localparam int ABS_W = 32;

    ld_regs_t          r_d, r_q;
    logic              wr_d, wr_q;
    logic [ADDR_W-1:0] waddr_d, waddr_q;
    logic [7:0]        wdata_d, wdata_q;

    logic       is_hex;
    logic [3:0] nib;
    logic       byte_vld;
    logic [7:0] byte_val;
    logic       in_rec, halted, take_char;
    logic [ABS_W-1:0] abs_addr;

    assign in_rec    = (r_q.st == ST_LEN) || (r_q.st == ST_AHI) || (r_q.st == ST_ALO) ||
                       (r_q.st == ST_TYPE) || (r_q.st == ST_DATA) || (r_q.st == ST_CSUM);
    assign halted    = (r_q.st == ST_DONE) || (r_q.st == ST_FAULT);
    assign take_char = rx_valid && in_rec && is_hex && !rx_frame_err;

    hexld_ascii u_ascii (
        .ch     (rx_byte),
        .is_hex (is_hex),
        .nib    (nib)
    );

    hexld_pair u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (r_q.st == ST_IDLE),
        .take     (take_char),
        .nib      (nib),
        .byte_vld (byte_vld),
        .byte_val (byte_val)
    );

    assign abs_addr = {12'h000, r_q.seg, 4'h0} + {16'h0000, (r_q.off + {8'h00, r_q.idx})};

    always_comb begin
        r_d     = r_q;
        wr_d    = 1'b0;
        waddr_d = waddr_q;
        wdata_d = wdata_q;
        if (!halted) begin
            if (rx_frame_err) begin
                r_d.st  = ST_FAULT;
                r_d.err = CODE_FRAME;
            end else if (rx_valid) begin
                if (r_q.st == ST_IDLE) begin
                    if (rx_byte == START_MARK) begin
                        r_d.st = ST_LEN;
                    end else begin
                        r_d.st  = ST_FAULT;
                        r_d.err = CODE_FORMAT;
                    end
                end else if (!is_hex) begin
                    r_d.st  = ST_FAULT;
                    r_d.err = CODE_FORMAT;
                end else if (byte_vld) begin
                    r_d.sum = r_q.sum + byte_val;
                    case (r_q.st)
                        ST_LEN: begin
                            r_d.len = byte_val;
                            r_d.sum = byte_val;
                            r_d.st  = ST_AHI;
                        end
                        ST_AHI: begin
                            r_d.off[15:8] = byte_val;
                            r_d.st        = ST_ALO;
                        end
                        ST_ALO: begin
                            r_d.off[7:0] = byte_val;
                            r_d.st       = ST_TYPE;
                        end
                        ST_TYPE: begin
                            r_d.rtype = byte_val;
                            r_d.idx   = 8'h00;
                            if (byte_val != REC_DATA && byte_val != REC_EOF &&
                                byte_val != REC_SEG) begin
                                r_d.st  = ST_FAULT;
                                r_d.err = CODE_TYPE;
                            end else if ((byte_val == REC_EOF && r_q.len != 8'd0) ||
                                         (byte_val == REC_SEG && r_q.len != 8'd2)) begin
                                r_d.st  = ST_FAULT;
                                r_d.err = CODE_LEN;
                            end else begin
                                r_d.st = (r_q.len == 8'd0) ? ST_CSUM : ST_DATA;
                            end
                        end
                        ST_DATA: begin
                            r_d.idx = r_q.idx + 8'd1;
                            if (r_q.rtype == REC_DATA) begin
                                wr_d    = 1'b1;
                                wdata_d = byte_val;
                                waddr_d = abs_addr[ADDR_W-1:0];
                            end else if (r_q.rtype == REC_SEG) begin
                                if (r_q.idx == 8'd0) r_d.seg_new[15:8] = byte_val;
                                else                 r_d.seg_new[7:0]  = byte_val;
                            end
                            if (r_q.idx == r_q.len - 8'd1) r_d.st = ST_CSUM;
                        end
                        ST_CSUM: begin
                            if (r_q.sum + byte_val != 8'h00) begin
                                r_d.st  = ST_FAULT;
                                r_d.err = CODE_SUM;
                            end else if (r_q.rtype == REC_EOF) begin
                                r_d.st = ST_DONE;
                            end else begin
                                if (r_q.rtype == REC_SEG) r_d.seg = r_q.seg_new;
                                r_d.st = ST_IDLE;
                            end
                        end
                        default: r_d.st = r_q.st;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            wr_q    <= 1'b0;
            waddr_q <= '0;
            wdata_q <= '0;
        end else begin
            r_q     <= r_d;
            wr_q    <= wr_d;
            waddr_q <= waddr_d;
            wdata_q <= wdata_d;
        end
    end

    assign wr_en    = wr_q;
    assign wr_addr  = waddr_q;
    assign wr_data  = wdata_q;
    assign busy     = in_rec;
    assign done     = (r_q.st == ST_DONE);
    assign err_code = r_q.err;

    // R11: a latched fault blocks the write port and freezes its code
    p_no_write_on_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != CODE_NONE) |-> !wr_en);
    p_code_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != CODE_NONE) |=> (err_code == $past(err_code)) && !busy);
    // R6: completion is sticky and never coexists with a fault
    p_done_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && (err_code == CODE_NONE) && !busy);
    // R9: only defined codes ever appear
    p_code_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code == CODE_NONE) || (err_code == CODE_FRAME) || (err_code == CODE_FORMAT) ||
        (err_code == CODE_TYPE) || (err_code == CODE_SUM) || (err_code == CODE_LEN));
    // R5: the base changes only as a checksum byte is taken
    p_seg_on_csum_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.seg) |-> $past(r_q.st == ST_CSUM));
    // R10: a framing strobe before completion always ends in code A1H
    p_frame_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame_err && !done && err_code == CODE_NONE) |=> (err_code == CODE_FRAME));
endmodule

// File: tb/hex_loader_test.sv
module hex_loader_test;
    localparam int AW = 20;
    localparam logic [31:0] AMASK = (32'h1 << AW) - 32'h1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_byte = 8'h00;
    logic          rx_frame_err = 1'b0;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          busy, done;
    logic [7:0]    err_code;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] wl_addr [0:63];
    logic [7:0]  wl_data [0:63];
    int          wl_cnt = 0;
    logic [7:0]  dbuf [0:31];

    always #4 clk = ~clk;

    hex_loader #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_frame_err(rx_frame_err), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .done(done), .err_code(err_code)
    );

    always @(negedge clk) begin
        if (wr_en && wl_cnt < 64) begin
            wl_addr[wl_cnt] = {{(32-AW){1'b0}}, wr_addr};
            wl_data[wl_cnt] = wr_data;
        end
        if (wr_en) wl_cnt = wl_cnt + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rx_valid = 1'b0;
        rx_frame_err = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        wl_cnt = 0;
    endtask

    task automatic send_char(input logic [7:0] c);
        rx_valid = 1'b1;
        rx_byte = c;
        @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [7:0] hexch(input logic [3:0] n, input bit lower);
        if (n < 4'd10) return 8'h30 + {4'h0, n};
        return (lower ? 8'h57 : 8'h37) + {4'h0, n};
    endfunction

    task automatic send_byte(input logic [7:0] b, input bit lower);
        send_char(hexch(b[7:4], lower));
        send_char(hexch(b[3:0], lower));
    endtask

    task automatic send_record(input logic [7:0] len, input logic [15:0] off,
                               input logic [7:0] typ, input logic [7:0] delta, input bit lower);
        logic [7:0] s;
        s = len + off[15:8] + off[7:0] + typ;
        send_char(8'h3A);
        send_byte(len, lower);
        send_byte(off[15:8], lower);
        send_byte(off[7:0], lower);
        send_byte(typ, lower);
        for (int i = 0; i < int'(len); i++) begin
            send_byte(dbuf[i], lower);
            s = s + dbuf[i];
        end
        send_byte((~s + 8'h01) + delta, lower);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] seg;
        logic [15:0] off;
        logic [31:0] ea;
        bit          hx;
        @(negedge clk);
        do_reset();
        // R1: reset state
        check("R1 wr_en", wr_en, 0);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 err", err_code, 8'h00);

        // R2: every byte value between records
        for (int c = 0; c < 256; c++) begin
            do_reset();
            send_char(c[7:0]);
            check("R2 err", err_code, (c == 8'h3A) ? 8'h00 : 8'hE1);
            check("R2 busy", busy, (c == 8'h3A) ? 1 : 0);
        end

        // R3: every character as the first digit of a record
        for (int c = 0; c < 256; c++) begin
            hx = (c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h46) ||
                 (c >= 8'h61 && c <= 8'h66);
            do_reset();
            send_char(8'h3A);
            send_char(c[7:0]);
            check("R3 err", err_code, hx ? 8'h00 : 8'hE1);
        end

        // R4 R5: data records of many lengths under changing bases, with offset wrap
        do_reset();
        seg = 16'h0000;
        for (int len = 1; len <= 16; len++) begin
            if (len % 3 == 0) begin
                seg = 16'h1234 * len[15:0];
                dbuf[0] = seg[15:8];
                dbuf[1] = seg[7:0];
                send_record(8'd2, 16'h0000, 8'h02, 8'h00, len[0]);
                check("R5 seg err", err_code, 8'h00);
            end
            off = 16'hFFF4 + 16'(len * 2);
            for (int i = 0; i < len; i++) dbuf[i] = 8'(len * 17 + i * 5);
            wl_cnt = 0;
            send_record(len[7:0], off, 8'h00, 8'h00, len[1]);
            check("R4 count", wl_cnt, len);
            check("R2 busy after csum", busy, 0);
            for (int i = 0; i < len; i++) begin
                ea = (({16'h0, seg} << 4) + {16'h0, 16'(off + i[15:0])}) & AMASK;
                check("R4 addr", wl_addr[i], ea);
                check("R5 data", wl_data[i], dbuf[i]);
            end
        end
        check("R9 good err", err_code, 8'h00);

        // R6: end of file, then ignored input
        send_record(8'd0, 16'h0000, 8'h01, 8'h00, 1'b0);
        check("R6 done", done, 1);
        check("R6 busy", busy, 0);
        wl_cnt = 0;
        dbuf[0] = 8'h55;
        send_record(8'd1, 16'h0010, 8'h00, 8'h00, 1'b0);
        send_char(8'h47);
        rx_frame_err = 1'b1;
        @(negedge clk);
        rx_frame_err = 1'b0;
        @(negedge clk);
        check("R6 no write", wl_cnt, 0);
        check("R6 err", err_code, 8'h00);
        check("R6 done held", done, 1);

        // R7: every illegal type
        for (int t = 3; t < 256; t++) begin
            do_reset();
            send_record(8'd0, 16'h0100, t[7:0], 8'h00, 1'b0);
            check("R7 err", err_code, 8'hE2);
        end

        // R8: length mismatches
        do_reset();
        dbuf[0] = 8'h00;
        send_record(8'd1, 16'h0000, 8'h01, 8'h00, 1'b0);
        check("R8 eof len1", err_code, 8'hE4);
        do_reset();
        send_record(8'd1, 16'h0000, 8'h02, 8'h00, 1'b0);
        check("R8 seg len1", err_code, 8'hE4);
        do_reset();
        dbuf[1] = 8'h01;
        dbuf[2] = 8'h02;
        send_record(8'd3, 16'h0000, 8'h02, 8'h00, 1'b0);
        check("R8 seg len3", err_code, 8'hE4);

        // R9: every nonzero checksum error
        for (int d = 1; d < 256; d++) begin
            do_reset();
            for (int i = 0; i < 4; i++) dbuf[i] = 8'(d + i);
            send_record(8'd4, 16'h2000, 8'h00, d[7:0], 1'b1);
            check("R9 err", err_code, 8'hE3);
        end

        // R11: after a fault, a valid record writes nothing and the code holds
        wl_cnt = 0;
        send_record(8'd4, 16'h2000, 8'h00, 8'h00, 1'b0);
        check("R11 no write", wl_cnt, 0);
        check("R11 code", err_code, 8'hE3);
        check("R11 busy", busy, 0);

        // R10: framing between records and mid-record with a byte in the same cycle
        do_reset();
        rx_frame_err = 1'b1;
        @(negedge clk);
        rx_frame_err = 1'b0;
        @(negedge clk);
        check("R10 idle", err_code, 8'hA1);
        do_reset();
        send_char(8'h3A);
        send_char(8'h30);
        rx_frame_err = 1'b1;
        rx_valid = 1'b1;
        rx_byte = 8'h31;
        @(negedge clk);
        rx_frame_err = 1'b0;
        rx_valid = 1'b0;
        @(negedge clk);
        check("R10 priority", err_code, 8'hA1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule